// File: doc/BRIEF.md
# Configurable Peripheral Request Arbiter

This block collects service requests aimed at a sequencer engine and picks one winner in each service slot. It has three kinds of source. Two external DMA request pins come in asynchronously. A set of serial-channel request lines and a set of lower-ranked peripheral request lines are both synchronous to the arbiter clock. The winner is reported as a one-hot grant vector, a valid flag and a binary index.

A 16-bit configuration register is loaded through a write strobe. It selects edge or level detection for each DMA pin and the rank of the DMA pair relative to the serial channels. It can also route the first DMA request to the engine as an interrupt.

Each DMA pin is brought into the clock domain through a two-flop synchronizer. In edge mode, a rising edge is held in a pending flag until that request wins a grant. In level mode, the synchronized pin is used directly as the request. Sources use fixed grant indices: DMA0 = 0 and DMA1 = 1, then serial channels starting at 2, then peripherals after the last serial channel.

Top module: `req_arb`

## Requirements
- R1: After reset, no grant is valid, `config_error` is 0 and `dma_irq` is 0. The configuration register is all zeros: both pins in edge mode, DMA placed first, interrupt off.
- R2: A word written with `cfg_wr` high is captured at that clock edge and governs arbitration from the next cycle. Its fields are: bit 0 = DMA0 level mode, bit 1 = DMA1 level mode, bits 3:2 = DMA placement, bit 4 = interrupt enable. Bits 15:5 have no effect.
- R3: With placement 00, a DMA request wins over every serial and peripheral request.
- R4: With placement 01, serial requests win over DMA requests, and DMA requests win over peripheral requests.
- R5: With placement 10, serial requests win first, then peripheral requests, and DMA requests only when nothing else is requesting.
- R6: Placement 11 arbitrates exactly as 00. Writing it sets `config_error`, which then stays 1 until reset.
- R7: In edge mode (mode bit 0), a rising edge on a DMA pin, even a single-cycle pulse, is held pending until that DMA request is granted. It clears on the clock edge that ends the granted cycle.
- R8: In level mode (mode bit 1), a DMA request exists only while its synchronized pin is high. Lowering the pin withdraws it.
- R9: While a pin is configured for level mode, its pending flag is cleared, so a rising edge captured earlier in edge mode is discarded.
- R10: Within a group the lower index wins: DMA0 over DMA1, and serial channel 0 over channel 1.
- R11: When `grant_enable` is high and any request is present, exactly one grant bit is set and `grant_valid` is 1. When `grant_enable` is low, no grant is issued and pending flags are kept.
- R12: `dma_irq` equals the effective DMA0 request when the interrupt-enable bit is 1, and is 0 when that bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Arbiter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Loads `cfg_wdata` into the configuration register |
| cfg_wdata | input | 16 | Configuration word |
| dma_pin | input | 2 | Asynchronous DMA request pins (bit 0 = DMA0) |
| ser_req | input | NUM_SER | Serial-channel requests, synchronous |
| per_req | input | NUM_PER | Lower-ranked peripheral requests, synchronous |
| grant_enable | input | 1 | Service slot open; a grant may be issued |
| grant_onehot | output | 2+NUM_SER+NUM_PER | One-hot grant, indexed as described above |
| grant_valid | output | 1 | A grant is being issued this cycle |
| grant_index | output | clog2(2+NUM_SER+NUM_PER) | Binary index of the granted source |
| dma_irq | output | 1 | Interrupt request derived from DMA0 |
| config_error | output | 1 | Sticky flag: reserved placement was written |

## Verification
The bench builds the arbiter with two serial channels and two peripheral lines. This gives six grant positions, so every group has both a lowest-index and a higher-index member. All three placement orders can then be told apart with a handful of request patterns. The synchronizer is kept at two stages, so the latency from a pin change to a visible request is short and exact. Single-cycle pulses can then be timed precisely against the edge-capture flag and a mode switch.

// File: rtl/req_arb_pkg.sv
package req_arb_pkg;

   typedef enum logic [1:0] {
      PLACE_FIRST = 2'b00,
      PLACE_MID   = 2'b01,
      PLACE_LAST  = 2'b10,
      PLACE_RSVD  = 2'b11
   } dma_place_e;

   typedef struct packed {
      logic [10:0] spare;
      logic        irq_en;
      dma_place_e  place;
      logic [1:0]  level_mode;
   } arb_cfg_t;

endpackage

// File: rtl/arb_sync.sv
module arb_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("arb_sync needs at least two stages");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/arb_dma_front.sv
module arb_dma_front (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_sync,
   input  logic level_mode,
   input  logic granted,
   output logic req
);
   logic prev_q;
   logic pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         prev_q <= pin_sync;
         if (level_mode) pend_q <= 1'b0;
         else            pend_q <= (pend_q & ~granted) | (pin_sync & ~prev_q);
      end
   end

   assign req = level_mode ? pin_sync : pend_q;
endmodule

// File: rtl/arb_lsb_pick.sv
module arb_lsb_pick #(
   parameter int W = 4
) (
   input  logic [W-1:0] req,
   output logic [W-1:0] pick,
   output logic         any
);
   assign pick = req & (~req + W'(1));
   assign any  = |req;
endmodule

// File: rtl/req_arb.sv
module req_arb
   import req_arb_pkg::*;
#(
   parameter int NUM_SER     = 4,
   parameter int NUM_PER     = 4,
   parameter int SYNC_STAGES = 2,
   localparam int N_DMA      = 2,
   localparam int N_REQ      = N_DMA + NUM_SER + NUM_PER,
   localparam int IDX_W      = $clog2(N_REQ)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_wr,
   input  logic [15:0]        cfg_wdata,
   input  logic [N_DMA-1:0]   dma_pin,
   input  logic [NUM_SER-1:0] ser_req,
   input  logic [NUM_PER-1:0] per_req,
   input  logic               grant_enable,
   output logic [N_REQ-1:0]   grant_onehot,
   output logic               grant_valid,
   output logic [IDX_W-1:0]   grant_index,
   output logic               dma_irq,
   output logic               config_error
);
   if (NUM_SER < 1) begin : g_bad_ser
      $error("req_arb needs at least one serial channel");
   end
   if (NUM_PER < 1) begin : g_bad_per
      $error("req_arb needs at least one peripheral line");
   end

   arb_cfg_t   cfg_q;
   logic       err_q;
   dma_place_e place_eff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
         err_q <= 1'b0;
      end else if (cfg_wr) begin
         cfg_q <= arb_cfg_t'(cfg_wdata);
         if (cfg_wdata[3:2] == PLACE_RSVD) err_q <= 1'b1;
      end
   end

   assign config_error = err_q;
   assign place_eff    = (cfg_q.place == PLACE_RSVD) ? PLACE_FIRST : cfg_q.place;

   logic [N_DMA-1:0] pin_s;
   logic [N_DMA-1:0] dma_eff;

   arb_sync #(.W(N_DMA), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(dma_pin), .q(pin_s)
   );

   for (genvar k = 0; k < N_DMA; k++) begin : g_dma
      arb_dma_front u_front (
         .clk       (clk),
         .rst_n     (rst_n),
         .pin_sync  (pin_s[k]),
         .level_mode(cfg_q.level_mode[k]),
         .granted   (grant_onehot[k]),
         .req       (dma_eff[k])
      );
   end

   logic [N_DMA-1:0]   d_one;
   logic [NUM_SER-1:0] s_one;
   logic [NUM_PER-1:0] p_one;
   logic d_any, s_any, p_any;

   arb_lsb_pick #(.W(N_DMA))   u_pick_d (.req(dma_eff), .pick(d_one), .any(d_any));
   arb_lsb_pick #(.W(NUM_SER)) u_pick_s (.req(ser_req), .pick(s_one), .any(s_any));
   arb_lsb_pick #(.W(NUM_PER)) u_pick_p (.req(per_req), .pick(p_one), .any(p_any));

   logic sel_d, sel_s, sel_p;

   always_comb begin
      sel_d = 1'b0;
      sel_s = 1'b0;
      sel_p = 1'b0;
      case (place_eff)
         PLACE_MID: begin
            sel_s = s_any;
            sel_d = !s_any && d_any;
            sel_p = !s_any && !d_any && p_any;
         end
         PLACE_LAST: begin
            sel_s = s_any;
            sel_p = !s_any && p_any;
            sel_d = !s_any && !p_any && d_any;
         end
         default: begin
            sel_d = d_any;
            sel_s = !d_any && s_any;
            sel_p = !d_any && !s_any && p_any;
         end
      endcase
      if (!grant_enable) begin
         sel_d = 1'b0;
         sel_s = 1'b0;
         sel_p = 1'b0;
      end
   end

   assign grant_onehot = {({NUM_PER{sel_p}} & p_one),
                          ({NUM_SER{sel_s}} & s_one),
                          ({N_DMA{sel_d}}   & d_one)};
   assign grant_valid  = sel_d | sel_s | sel_p;

   always_comb begin
      grant_index = '0;
      for (int i = 0; i < N_REQ; i++) begin
         if (grant_onehot[i]) grant_index = grant_index | IDX_W'(i);
      end
   end

   assign dma_irq = cfg_q.irq_en & dma_eff[0];
endmodule

// File: rtl/req_arb_checker.sv
module req_arb_checker #(
   parameter int NUM_SER = 4,
   parameter int NUM_PER = 4,
   localparam int N_REQ  = 2 + NUM_SER + NUM_PER
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cfg_wr,
   input logic [15:0]        cfg_wdata,
   input logic [NUM_SER-1:0] ser_req,
   input logic               grant_enable,
   input logic [N_REQ-1:0]   grant_onehot,
   input logic               grant_valid,
   input logic               irq_en,
   input logic               dma_irq,
   input logic               config_error
);
   assert_single_grant_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_onehot));

   assert_valid_matches_R11: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid == (grant_onehot != '0));

   assert_idle_slot_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !grant_enable |-> grant_onehot == '0);

   assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      config_error |=> config_error);

   assert_err_on_rsvd_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_wdata[3:2] == 2'b11) |=> config_error);

   assert_irq_masked_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> !dma_irq);

   // serial channels always outrank peripherals, whatever the DMA placement (R4, R5)
   assert_ser_over_per_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_onehot[N_REQ-1:2+NUM_SER] != '0) |-> ser_req == '0);
endmodule

bind req_arb req_arb_checker #(.NUM_SER(NUM_SER), .NUM_PER(NUM_PER)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_wr      (cfg_wr),
   .cfg_wdata   (cfg_wdata),
   .ser_req     (ser_req),
   .grant_enable(grant_enable),
   .grant_onehot(grant_onehot),
   .grant_valid (grant_valid),
   .irq_en      (cfg_q.irq_en),
   .dma_irq     (dma_irq),
   .config_error(config_error)
);

// File: tb/req_arb_tb.sv
module req_arb_tb;
   localparam int NS = 2;
   localparam int NP = 2;
   localparam int N  = 2 + NS + NP;
   localparam int IW = $clog2(N);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_wr = 1'b0;
   logic [15:0]   cfg_wdata = '0;
   logic [1:0]    dma_pin = '0;
   logic [NS-1:0] ser_req = '0;
   logic [NP-1:0] per_req = '0;
   logic          grant_enable = 1'b0;
   logic [N-1:0]  grant_onehot;
   logic          grant_valid;
   logic [IW-1:0] grant_index;
   logic          dma_irq;
   logic          config_error;

   always #5 clk = ~clk;

   req_arb #(.NUM_SER(NS), .NUM_PER(NP)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .dma_pin(dma_pin), .ser_req(ser_req), .per_req(per_req),
      .grant_enable(grant_enable), .grant_onehot(grant_onehot),
      .grant_valid(grant_valid), .grant_index(grant_index),
      .dma_irq(dma_irq), .config_error(config_error)
   );

   typedef struct {
      bit    valid;
      int    idx;
      bit    err;
      bit    irq;
      string tag;
   } exp_t;

   exp_t q[$];
   int   checks = 0;
   int   fails  = 0;
   bit   done   = 1'b0;

   // monitor: pops every queued expectation at the falling edge
   initial begin
      forever begin
         @(negedge clk);
         while (q.size() > 0) begin
            exp_t e;
            logic [N-1:0] oh;
            e  = q.pop_front();
            oh = e.valid ? (N'(1) << e.idx) : '0;
            checks++;
            if (grant_valid !== e.valid || grant_onehot !== oh ||
                (e.valid && grant_index !== IW'(e.idx)) ||
                config_error !== e.err || dma_irq !== e.irq) begin
               fails++;
               $display("FAIL %s: valid=%0b/%0b onehot=%b/%b idx=%0d/%0d err=%0b/%0b irq=%0b/%0b",
                        e.tag, grant_valid, e.valid, grant_onehot, oh, grant_index, e.idx,
                        config_error, e.err, dma_irq, e.irq);
            end
         end
      end
   end

   task automatic step(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic expect_out(bit v, int idx, bit err, bit irq, string tag);
      exp_t e;
      e.valid = v; e.idx = idx; e.err = err; e.irq = irq; e.tag = tag;
      q.push_back(e);
      step(1);
   endtask

   task automatic write_cfg(logic [15:0] w);
      cfg_wr = 1'b1;
      cfg_wdata = w;
      step(1);
      cfg_wr = 1'b0;
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      expect_out(0, 0, 0, 0, "R1 reset idle");

      // level mode both, DMA placed first
      write_cfg(16'h0003);
      dma_pin = 2'b01; ser_req = 2'b11; per_req = 2'b11; grant_enable = 1'b1;
      step(3);
      expect_out(1, 0, 0, 0, "R3 dma above serial");
      dma_pin = 2'b11;
      step(3);
      expect_out(1, 0, 0, 0, "R10 dma0 over dma1");

      write_cfg(16'h0007);
      expect_out(1, 2, 0, 0, "R2 R4 serial above dma");
      ser_req = 2'b00;
      expect_out(1, 0, 0, 0, "R4 dma above peripheral");
      ser_req = 2'b10;
      expect_out(1, 3, 0, 0, "R4 serial1 above dma");

      write_cfg(16'h002B);
      ser_req = 2'b11;
      expect_out(1, 2, 0, 0, "R5 serial first");
      ser_req = 2'b00;
      expect_out(1, 4, 0, 0, "R5 peripheral above dma");
      per_req = 2'b10;
      expect_out(1, 5, 0, 0, "R10 R5 peripheral1");
      per_req = 2'b00;
      expect_out(1, 0, 0, 0, "R5 dma last");

      dma_pin = 2'b00;
      step(3);
      ser_req = 2'b11;
      expect_out(1, 2, 0, 0, "R10 serial0 over serial1");
      grant_enable = 1'b0;
      expect_out(0, 0, 0, 0, "R11 no grant when disabled");
      grant_enable = 1'b1;
      ser_req = 2'b00;

      // level withdraw
      write_cfg(16'h0003);
      dma_pin = 2'b01;
      step(3);
      expect_out(1, 0, 0, 0, "R8 level request");
      dma_pin = 2'b00;
      step(3);
      expect_out(0, 0, 0, 0, "R8 level withdrawn");

      // interrupt path
      write_cfg(16'h0013);
      dma_pin = 2'b01;
      step(3);
      expect_out(1, 0, 0, 1, "R12 irq enabled");
      write_cfg(16'h0003);
      expect_out(1, 0, 0, 0, "R12 irq disabled");
      dma_pin = 2'b00;
      step(3);

      // edge capture of a one-cycle pulse
      write_cfg(16'h0000);
      grant_enable = 1'b0;
      dma_pin = 2'b10;
      step(1);
      dma_pin = 2'b00;
      step(5);
      expect_out(0, 0, 0, 0, "R11 pending held while disabled");
      grant_enable = 1'b1;
      expect_out(1, 1, 0, 0, "R7 pulse kept pending");
      expect_out(0, 0, 0, 0, "R7 pending cleared by grant");

      // edge -> level discards pending
      grant_enable = 1'b0;
      dma_pin = 2'b01;
      step(1);
      dma_pin = 2'b00;
      step(5);
      write_cfg(16'h0001);
      step(1);
      write_cfg(16'h0000);
      step(1);
      grant_enable = 1'b1;
      expect_out(0, 0, 0, 0, "R9 pending discarded");

      // reserved placement
      write_cfg(16'h000F);
      dma_pin = 2'b01; ser_req = 2'b11;
      step(3);
      expect_out(1, 0, 1, 0, "R6 reserved acts as first");
      write_cfg(16'h0003);
      expect_out(1, 0, 1, 0, "R6 error sticky");

      step(2);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule